// File: doc/BRIEF.md
# ADC Power Mode Controller

This block sequences the idle and wake-up behaviour of a two-channel sampling converter's digital back end. A chip-wide active-low power-down pin and a per-channel active-low sleep bus are sampled on the converter clock. From them the block derives, for each channel, a bias enable, a clock enable and a data-valid flag, plus one enable for the shared internal clock. Each channel's sample word passes through a register that is forced to zero whenever power-down is requested.

Waking takes time. When a channel is asked to run, its valid flag stays low for a startup count. That count is long when the channel is leaving power-down, because the references must settle again, and short when it is leaving sleep. The count starts over whenever the requested mode changes before it has finished. The block also remembers whether power-down has been applied at least once since reset. Until that has happened, requests to run or to sleep are refused and both channels stay powered down.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: While reset is asserted, every output is zero, with the mode of both channels at power-down.
- R2: Until power-down has been applied once after reset, the sleep bus is ignored: `ch_en`, `ch_clk_en` and `valid` stay zero.
- R3: `armed` rises on the clock edge that samples `pd_n` low and then stays high until reset.
- R4: `pd_n` low overrides the sleep bus. On the next edge, both channels go to power-down, `ch_en`, `ch_clk_en` and `valid` clear, and `core_clk_en` goes low.
- R5: Each channel's data output is zero after any edge that sampled a power-down request.
- R6: When armed and `pd_n` is high, sleep bus bit i = 1 makes channel i run (`ch_en` and `ch_clk_en` high). Bit i = 0 puts channel i to sleep (`ch_en` high, `ch_clk_en` low). So 00 = both asleep, 01 = only channel 0 runs, 10 = only channel 1 runs, 11 = both run. `core_clk_en` is high while either channel is not powered down.
- R7: A channel asked to run while in power-down raises `valid` T_PD+1 edges after the first edge that samples the request.
- R8: A channel asked to run while asleep raises `valid` T_SLP+1 edges after the first edge that samples the request.
- R9: A change of requested mode before `valid` rises restarts the count. The new count is chosen from the mode being left at that moment.
- R10: While `valid` is high, the channel's data output takes the input word one edge later. When the channel is neither valid nor requested off, the output holds its value.
- R11: A running channel whose request changes to sleep or power-down drops `valid` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pd_n | input | 1 | Active-low full power-down request |
| sleep_n | input | NCH | Active-low per-channel sleep request, bit i for channel i |
| din | input | NCH*DW | Channel sample words, channel i at bits i*DW upward |
| ch_en | output | NCH | Channel bias powered (sleep or run) |
| ch_clk_en | output | NCH | Channel clock enabled (run) |
| valid | output | NCH | Channel data valid after startup |
| core_clk_en | output | 1 | Shared internal clock enable |
| armed | output | 1 | Initial power-down has been seen |
| dout | output | NCH*DW | Gated channel sample words |

## Verification
The bench builds the block with T_PD = 6, T_SLP = 2 and DW = 8. Because the two startup counts differ and are short, a wake from power-down can be told apart from a wake from sleep in a few dozen cycles. The short counts also let the bench interrupt a wake mid-count with a sleep request or with a power-down pulse, and then measure the restarted count. The narrow data word lets each channel capture a fresh random sample on every clock, so it is visible whether the output holds or updates.

// File: rtl/adc_pm_pkg.sv
package adc_pm_pkg;
  typedef enum logic [1:0] {
    PM_OFF = 2'd0,
    PM_NAP = 2'd1,
    PM_RUN = 2'd2
  } pm_mode_e;
endpackage

// File: rtl/pm_arm.sv
module pm_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n,
  output logic armed
);
  logic armed_q;
  logic armed_we;

  assign armed_we = !pd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else if (armed_we) armed_q <= 1'b1;
  end

  assign armed = armed_q;

  // R3
  armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);
  // R3
  armed_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> armed_q);
endmodule

// File: rtl/pm_chan.sv
module pm_chan
  import adc_pm_pkg::*;
#(
  parameter int DW    = 13,
  parameter int T_PD  = 12,
  parameter int T_SLP = 3,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pm_mode_e      req,
  input  logic [DW-1:0] din,
  output logic          ch_en,
  output logic          ch_clk_en,
  output logic          valid,
  output logic [DW-1:0] dout
);
  localparam logic [CW-1:0] CNT_PD  = CW'(T_PD);
  localparam logic [CW-1:0] CNT_SLP = CW'(T_SLP);

  pm_mode_e      mode_q, mode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] dout_q, dout_d;
  logic          dout_we;
  logic          valid_c;

  assign valid_c = (mode_q == PM_RUN) && (cnt_q == '0);

  always_comb begin
    mode_d = req;
    cnt_d  = cnt_q;
    if (req == PM_RUN) begin
      if (mode_q != PM_RUN)
        cnt_d = (mode_q == PM_OFF) ? CNT_PD : CNT_SLP;
      else if (cnt_q != '0)
        cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_d = '0;
    end
  end

  always_comb begin
    dout_we = (req == PM_OFF) || valid_c;
    dout_d  = (req == PM_OFF) ? '0 : din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_OFF;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else if (dout_we) dout_q <= dout_d;
  end

  assign ch_en     = (mode_q != PM_OFF);
  assign ch_clk_en = (mode_q == PM_RUN);
  assign valid     = valid_c;
  assign dout      = dout_q;

  // R5
  pd_clears_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req == PM_OFF) |=> (dout == '0));
  // R11
  leave_run_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req != PM_RUN) |=> !valid);
  // R9
  entry_not_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req == PM_RUN && mode_q != PM_RUN) |=> !valid);
  // R10
  data_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && req != PM_OFF) |=> (dout == $past(din)));
  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ((T_PD > T_SLP) ? CNT_PD : CNT_SLP));
endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
  import adc_pm_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int DW    = 13,
  parameter int T_PD  = 12,
  parameter int T_SLP = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_n,
  input  logic [NCH-1:0]    sleep_n,
  input  logic [NCH*DW-1:0] din,
  output logic [NCH-1:0]    ch_en,
  output logic [NCH-1:0]    ch_clk_en,
  output logic [NCH-1:0]    valid,
  output logic              core_clk_en,
  output logic              armed,
  output logic [NCH*DW-1:0] dout
);
  localparam int TMAX = (T_PD > T_SLP) ? T_PD : T_SLP;
  localparam int CW   = $clog2(TMAX + 1);

  logic armed_w;

  pm_arm u_arm (
    .clk   (clk),
    .rst_n (rst_n),
    .pd_n  (pd_n),
    .armed (armed_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pm_mode_e req;

    always_comb begin
      if (!pd_n || !armed_w) req = PM_OFF;
      else if (sleep_n[g])   req = PM_RUN;
      else                   req = PM_NAP;
    end

    pm_chan #(
      .DW    (DW),
      .T_PD  (T_PD),
      .T_SLP (T_SLP),
      .CW    (CW)
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .din       (din[g*DW +: DW]),
      .ch_en     (ch_en[g]),
      .ch_clk_en (ch_clk_en[g]),
      .valid     (valid[g]),
      .dout      (dout[g*DW +: DW])
    );
  end

  assign core_clk_en = |ch_en;
  assign armed       = armed_w;

  // R2
  no_run_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (ch_en == '0 && valid == '0));
  // R4
  pd_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (!core_clk_en && ch_clk_en == '0 && valid == '0));
endmodule

// File: tb/adc_pwr_ctrl_test.sv
module adc_pwr_ctrl_test;
  localparam int NCH = 2;
  localparam int DW = 8;
  localparam int TPD = 6;
  localparam int TSL = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic pd_n;
  logic [NCH-1:0] sleep_n;
  logic [NCH*DW-1:0] din;
  logic [NCH-1:0] ch_en, ch_clk_en, valid;
  logic core_clk_en, armed;
  logic [NCH*DW-1:0] dout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_mode [NCH];
  int m_cnt [NCH];
  logic [DW-1:0] m_dout [NCH];
  int m_armed;
  logic [NCH-1:0] seen_valid;

  always #4 clk = ~clk;

  adc_pwr_ctrl #(.NCH(NCH), .DW(DW), .T_PD(TPD), .T_SLP(TSL)) uut (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .sleep_n(sleep_n), .din(din),
    .ch_en(ch_en), .ch_clk_en(ch_clk_en), .valid(valid),
    .core_clk_en(core_clk_en), .armed(armed), .dout(dout)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int anyon = 0;
    chk("R3 armed", armed, m_armed);
    for (int i = 0; i < NCH; i++) begin
      if (m_mode[i] != 0) anyon = 1;
      chk("R6 ch_en", ch_en[i], m_mode[i] != 0);
      chk("R6 ch_clk_en", ch_clk_en[i], m_mode[i] == 2);
      chk("R7 valid", valid[i], (m_mode[i] == 2) && (m_cnt[i] == 0));
      chk("R10 dout", dout[i*DW +: DW], m_dout[i]);
    end
    chk("R4 core_clk_en", core_clk_en, anyon);
  endtask

  // At a falling edge: compare, then drive new inputs and advance the model.
  task automatic step(bit pd, logic [NCH-1:0] sl);
    @(negedge clk);
    seen_valid = valid;
    compare_all();
    pd_n = pd;
    sleep_n = sl;
    for (int i = 0; i < NCH; i++) din[i*DW +: DW] = DW'($urandom);
    for (int i = 0; i < NCH; i++) begin
      int rq;
      bit vnow;
      rq = (!pd || m_armed == 0) ? 0 : (sl[i] ? 2 : 1);
      vnow = (m_mode[i] == 2) && (m_cnt[i] == 0);
      if (rq == 0) m_dout[i] = '0;
      else if (vnow) m_dout[i] = din[i*DW +: DW];
      if (rq == 2) begin
        if (m_mode[i] != 2) m_cnt[i] = (m_mode[i] == 0) ? TPD : TSL;
        else if (m_cnt[i] > 0) m_cnt[i]--;
      end else m_cnt[i] = 0;
      m_mode[i] = rq;
    end
    if (!pd) m_armed = 1;
  endtask

  // Hold a request and count edges until channel ch reports valid.
  task automatic measure(string tag, bit pd, logic [NCH-1:0] sl, int ch, int exp);
    int k = 0;
    step(pd, sl);
    for (int n = 1; n <= 40; n++) begin
      step(pd, sl);
      k = n;
      if (seen_valid[ch]) break;
    end
    chk(tag, k, exp);
  endtask

  initial begin
    rst_n = 1'b0; pd_n = 1'b1; sleep_n = 2'b11; din = '0;
    m_armed = 0;
    for (int i = 0; i < NCH; i++) begin m_mode[i] = 0; m_cnt[i] = 0; m_dout[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ch_en", ch_en, 0);
    chk("R1 valid", valid, 0);
    chk("R1 core_clk_en", core_clk_en, 0);
    chk("R1 armed", armed, 0);
    chk("R1 dout", int'(dout == '0), 1);
    rst_n = 1'b1;
    // R2 run requests before the first power-down are ignored
    repeat (5) step(1'b1, 2'b11);
    @(negedge clk);
    chk("R2 ch_clk_en", ch_clk_en, 0);
    chk("R2 valid", valid, 0);
    // R3 / R4 first power-down arms the block
    repeat (3) step(1'b0, 2'b11);
    step(1'b0, 2'b11);
    chk("R3 armed sticky", armed, 1);
    chk("R4 core clock off", core_clk_en, 0);
    // R7 wake from power-down
    measure("R7 wake from power-down", 1'b1, 2'b11, 0, TPD + 1);
    repeat (3) step(1'b1, 2'b11);
    // R11 running channel sent to sleep
    step(1'b1, 2'b00);
    step(1'b1, 2'b00);
    chk("R11 valid drop", seen_valid, 0);
    // R6 sleep keeps bias but stops channel clocks
    chk("R6 sleep bias", ch_en, 2'b11);
    chk("R6 sleep clock", ch_clk_en, 2'b00);
    repeat (2) step(1'b1, 2'b00);
    // R8 wake from sleep
    measure("R8 wake from sleep", 1'b1, 2'b11, 1, TSL + 1);
    // R6 single-channel encodings
    repeat (4) step(1'b1, 2'b01);
    chk("R6 code 01 clk", ch_clk_en, 2'b01);
    repeat (4) step(1'b1, 2'b10);
    chk("R6 code 10 clk", ch_clk_en, 2'b10);
    repeat (3) step(1'b1, 2'b00);
    // R9 interrupt a sleep wake with sleep again, then restart
    step(1'b1, 2'b11);
    step(1'b1, 2'b00);
    measure("R9 restart after sleep", 1'b1, 2'b11, 0, TSL + 1);
    // R9 interrupt a sleep wake with a power-down pulse: long count applies
    repeat (2) step(1'b1, 2'b00);
    step(1'b1, 2'b11);
    step(1'b0, 2'b11);
    measure("R9 restart after power-down", 1'b1, 2'b11, 0, TPD + 1);
    // R5 power-down clears data while channels were valid
    repeat (4) step(1'b1, 2'b11);
    step(1'b0, 2'b11);
    step(1'b0, 2'b11);
    chk("R5 dout cleared", int'(dout == '0), 1);
    // R10 hold during startup: mixed traffic compared each cycle
    for (int n = 0; n < 60; n++) step(($urandom % 8) != 0, 2'($urandom));
    repeat (2) step(1'b1, 2'b11);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule